// File: doc/BRIEF.md
# Global Exclusive Monitor

This block keeps the shared side of the exclusive-access protocol for a group of requester ports that share one memory. Each port sends three kinds of notification: a load-exclusive that opens a reservation, a plain store, and a store-exclusive that asks whether a conditional write may go ahead. A port can also withdraw from the set of ports the monitor watches. For every port the block holds an Open/Exclusive flag, a tagged address, a membership bit and a small failure-budget counter. For each store-exclusive it returns a pass or fail verdict, and a pass cancels competing reservations on the same address granule.

Only one notification is taken per cycle. A fixed-priority grant picks the lowest-numbered port that has a valid request, and the identity of that port is the requester. The verdict for an accepted store-exclusive appears one cycle later as a strobe together with the port number. A failure-budget counter for each port makes every (FAIL_MAX+1)-th exact-match store-exclusive fail, so that software retry loops are exercised even when no other port competes.

Top module: `gx_monitor`

## Requirements
- R1: After reset every port is Open with tag zero, is not in the active set and has a zero failure counter. No response is given, and a store-exclusive from any port fails.
- R2: Each cycle `req_ready` is asserted only for the lowest-indexed port whose `req_valid` is high. At most one notification is accepted per cycle. Port i's op is `req_op[2i+1:2i]` and its address is `req_addr[ADDR_W*i +: ADDR_W]`.
- R3: An accepted load-exclusive (op 2'b01) sets the requester to Exclusive, stores the address as its tag and adds the port to the active set.
- R4: An accepted plain store (op 2'b10) from any port returns every active Exclusive port to Open, whatever its tag. This includes the requester when it is active.
- R5: A store-exclusive (op 2'b11) can pass only if the requester is Exclusive and the address equals its tag exactly, with no masking. A matching requester returns to Open.
- R6: A store-exclusive from an Open port, or one whose address differs from the tag, fails and changes the state of no port. A mismatching requester keeps its reservation.
- R7: When a store-exclusive passes, every other active Exclusive port whose tag lies in the same granule (address bits above GRAN_BITS equal) goes to Open. Active ports in other granules keep their reservations.
- R8: Each exact match compares the requester's counter with FAIL_MAX. If the counter is below FAIL_MAX, the counter increments and the store-exclusive passes. Otherwise the counter returns to zero and the store-exclusive fails. With the counter starting at zero, the 64th, 128th, … matches fail under the default of 63.
- R9: A drop (op 2'b00) removes the requester from the active set without changing its flag or tag. Other ports' stores and passing store-exclusives then leave it untouched, until its next load-exclusive adds it back.
- R10: `rsp_valid` pulses for exactly one cycle, one cycle after a store-exclusive is accepted, carrying `rsp_port` and `rsp_pass`. No other op produces a response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_PORTS | Request present, one bit per port |
| req_op | input | 2*N_PORTS | Op per port: 00 drop, 01 load-exclusive, 10 store, 11 store-exclusive |
| req_addr | input | ADDR_W*N_PORTS | Byte address per port |
| req_ready | output | N_PORTS | Acceptance, one-hot or zero |
| rsp_valid | output | 1 | Store-exclusive verdict strobe |
| rsp_port | output | PORT_W | Port the verdict belongs to |
| rsp_pass | output | 1 | 1 = store-exclusive may write, 0 = failed |

## Verification
The store-exclusive is tried after its own load-exclusive at the exact address, at a different address inside the same granule, and with no reservation at all. These cases separate exact matching from granule matching and from the Open state. Competing reservations are placed in the same granule and in a neighbouring granule, so the snoop clear must tell the two apart. A plain store at an unrelated address checks that stores clear reservations regardless of address. Drops are followed by foreign stores and passing store-exclusives, which shows that membership, not the flag, gates notification. Simultaneous requests from several ports show the priority grant. A run of 128 load/store-exclusive pairs on one port must give exactly two budget failures.

// File: rtl/gx_pkg.sv
package gx_pkg;
  typedef enum logic [1:0] {
    GX_DROP  = 2'b00,
    GX_LDEX  = 2'b01,
    GX_STORE = 2'b10,
    GX_STEX  = 2'b11
  } gx_op_e;

  function automatic logic gx_is_stex(input gx_op_e op);
    return op == GX_STEX;
  endfunction
endpackage

// File: rtl/gx_arbiter.sv
module gx_arbiter #(
  parameter int N_PORTS = 4,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic [N_PORTS-1:0] req,
  output logic [N_PORTS-1:0] grant,
  output logic [PORT_W-1:0]  idx,
  output logic               any
);
  logic [N_PORTS-1:0] blocked;

  assign blocked[0] = 1'b0;
  genvar gi;
  generate
    for (gi = 1; gi < N_PORTS; gi++) begin : g_chain
      assign blocked[gi] = blocked[gi-1] | req[gi-1];
    end
  endgenerate

  assign grant = req & ~blocked;
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (grant[i]) idx = PORT_W'(i);
    end
  end
endmodule

// File: rtl/gx_slot.sv
module gx_slot
  import gx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 3,
  parameter int FAIL_MAX  = 63,
  localparam int CW = $clog2(FAIL_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fire,
  input  gx_op_e            ev_op,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              is_self,
  input  logic              peer_pass,
  output logic              excl_o,
  output logic              member_o,
  output logic              match_o,
  output logic              pass_o
);
  logic              excl_q;
  logic              member_q;
  logic [ADDR_W-1:0] tag_q;
  logic [CW-1:0]     cnt_q;

  function automatic logic same_granule(input logic [ADDR_W-1:0] a,
                                        input logic [ADDR_W-1:0] b);
    return (a >> GRAN_BITS) == (b >> GRAN_BITS);
  endfunction

  function automatic logic budget_spent(input logic [CW-1:0] c);
    return c >= CW'(FAIL_MAX);
  endfunction

  logic snoop_hit;
  assign match_o   = excl_q && (tag_q == ev_addr);
  assign pass_o    = match_o && !budget_spent(cnt_q);
  assign snoop_hit = peer_pass && member_q && excl_q && same_granule(tag_q, ev_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      excl_q   <= 1'b0;
      member_q <= 1'b0;
      tag_q    <= '0;
      cnt_q    <= '0;
    end else if (ev_fire) begin
      unique case (ev_op)
        GX_DROP: begin
          if (is_self) member_q <= 1'b0;
        end
        GX_LDEX: begin
          if (is_self) begin
            excl_q   <= 1'b1;
            tag_q    <= ev_addr;
            member_q <= 1'b1;
          end
        end
        GX_STORE: begin
          if (member_q && excl_q) begin
            excl_q <= 1'b0;
            tag_q  <= '0;
          end
        end
        GX_STEX: begin
          if (is_self) begin
            if (match_o) begin
              excl_q <= 1'b0;
              tag_q  <= '0;
              cnt_q  <= budget_spent(cnt_q) ? '0 : cnt_q + 1'b1;
            end
          end else if (snoop_hit) begin
            excl_q <= 1'b0;
            tag_q  <= '0;
          end
        end
      endcase
    end
  end

  assign excl_o   = excl_q;
  assign member_o = member_q;
endmodule

// File: rtl/gx_verdict.sv
module gx_verdict
  import gx_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_fire,
  input  gx_op_e             ev_op,
  input  logic [PORT_W-1:0]  ev_idx,
  input  logic [N_PORTS-1:0] grant,
  input  logic [N_PORTS-1:0] slot_pass,
  output logic               pass_now,
  output logic               rsp_valid,
  output logic [PORT_W-1:0]  rsp_port,
  output logic               rsp_pass
);
  logic stex_fire;
  assign stex_fire = ev_fire && gx_is_stex(ev_op);
  assign pass_now  = stex_fire && |(slot_pass & grant);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_pass  <= 1'b0;
    end else begin
      rsp_valid <= stex_fire;
      if (stex_fire) begin
        rsp_port <= ev_idx;
        rsp_pass <= pass_now;
      end
    end
  end
endmodule

// File: rtl/gx_monitor.sv
module gx_monitor
  import gx_pkg::*;
#(
  parameter int N_PORTS   = 4,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 3,
  parameter int FAIL_MAX  = 63,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PORTS-1:0]         req_valid,
  input  logic [2*N_PORTS-1:0]       req_op,
  input  logic [ADDR_W*N_PORTS-1:0]  req_addr,
  output logic [N_PORTS-1:0]         req_ready,
  output logic                       rsp_valid,
  output logic [PORT_W-1:0]          rsp_port,
  output logic                       rsp_pass
);
  logic [N_PORTS-1:0] grant;
  logic [PORT_W-1:0]  ev_idx;
  logic               ev_fire;
  gx_op_e             ev_op;
  logic [ADDR_W-1:0]  ev_addr;
  logic [N_PORTS-1:0] slot_excl;
  logic [N_PORTS-1:0] slot_member;
  logic [N_PORTS-1:0] slot_match;
  logic [N_PORTS-1:0] slot_pass;
  logic               pass_now;
  logic               req_match;

  gx_arbiter #(.N_PORTS(N_PORTS)) u_arb (
    .req   (req_valid),
    .grant (grant),
    .idx   (ev_idx),
    .any   (ev_fire)
  );

  always_comb begin
    ev_op   = GX_DROP;
    ev_addr = '0;
    for (int i = 0; i < N_PORTS; i++) begin
      if (grant[i]) begin
        ev_op   = gx_op_e'(req_op[2*i +: 2]);
        ev_addr = req_addr[ADDR_W*i +: ADDR_W];
      end
    end
  end

  genvar gp;
  generate
    for (gp = 0; gp < N_PORTS; gp++) begin : g_slot
      gx_slot #(
        .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS), .FAIL_MAX(FAIL_MAX)
      ) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev_fire  (ev_fire),
        .ev_op    (ev_op),
        .ev_addr  (ev_addr),
        .is_self  (grant[gp]),
        .peer_pass(pass_now),
        .excl_o   (slot_excl[gp]),
        .member_o (slot_member[gp]),
        .match_o  (slot_match[gp]),
        .pass_o   (slot_pass[gp])
      );
    end
  endgenerate

  assign req_match = |(slot_match & grant);

  gx_verdict #(.N_PORTS(N_PORTS)) u_verdict (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_fire  (ev_fire),
    .ev_op    (ev_op),
    .ev_idx   (ev_idx),
    .grant    (grant),
    .slot_pass(slot_pass),
    .pass_now (pass_now),
    .rsp_valid(rsp_valid),
    .rsp_port (rsp_port),
    .rsp_pass (rsp_pass)
  );

  assign req_ready = grant;
endmodule

// File: rtl/gx_monitor_chk.sv
module gx_monitor_chk
  import gx_pkg::*;
#(
  parameter int N_PORTS = 4,
  localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_PORTS-1:0] req_valid,
  input logic [N_PORTS-1:0] req_ready,
  input logic               ev_fire,
  input logic [1:0]         ev_op,
  input logic [PORT_W-1:0]  ev_idx,
  input logic [N_PORTS-1:0] slot_excl,
  input logic [N_PORTS-1:0] slot_member,
  input logic               req_match,
  input logic               rsp_valid,
  input logic [PORT_W-1:0]  rsp_port,
  input logic               rsp_pass
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));

  assert_grant_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0);

  assert_ldex_sets_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_LDEX) |=> (slot_excl[$past(ev_idx)] && slot_member[$past(ev_idx)]));

  assert_store_clears_members_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_STORE) |=> ((slot_excl & $past(slot_member)) == '0));

  assert_no_match_no_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_STEX && !req_match) |=> !rsp_pass);

  assert_fail_keeps_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_STEX && !req_match) |=> $stable(slot_excl));

  assert_drop_leaves_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_DROP) |=> !slot_member[$past(ev_idx)]);

  assert_rsp_after_stex_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_op == GX_STEX) |=> (rsp_valid && rsp_port == $past(ev_idx)));

  assert_no_rsp_otherwise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_fire && ev_op == GX_STEX) |=> !rsp_valid);
endmodule

bind gx_monitor gx_monitor_chk #(.N_PORTS(N_PORTS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .ev_fire    (ev_fire),
  .ev_op      (ev_op),
  .ev_idx     (ev_idx),
  .slot_excl  (slot_excl),
  .slot_member(slot_member),
  .req_match  (req_match),
  .rsp_valid  (rsp_valid),
  .rsp_port   (rsp_port),
  .rsp_pass   (rsp_pass)
);

// File: tb/gx_monitor_bench.sv
`timescale 1ns/1ps
module gx_monitor_bench;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int GB = 3;
  localparam int FM = 63;
  localparam logic [1:0] OP_DROP = 2'b00, OP_LDEX = 2'b01, OP_ST = 2'b10, OP_STEX = 2'b11;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NP-1:0]   req_valid = '0;
  logic [2*NP-1:0] req_op = '0;
  logic [AW*NP-1:0] req_addr = '0;
  logic [NP-1:0]   req_ready;
  logic            rsp_valid;
  logic [1:0]      rsp_port;
  logic            rsp_pass;

  always #4 clk = ~clk;

  gx_monitor #(.N_PORTS(NP), .ADDR_W(AW), .GRAN_BITS(GB), .FAIL_MAX(FM)) u_gx_monitor (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_port(rsp_port), .rsp_pass(rsp_pass)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  bit          m_excl[NP];
  bit          m_mem[NP];
  logic [31:0] m_tag[NP];
  int          m_cnt[NP];
  bit          e_v = 0;
  int          e_port = 0;
  bit          e_pass = 0;
  string       e_tag = "R1";
  int          trk_port = -1;
  int          trk_fail = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [NP-1:0] v, input logic [2*NP-1:0] ops,
                       input logic [AW*NP-1:0] addrs, input string tag);
    int g;
    @(negedge clk);
    // verdict from the previous cycle
    check(rsp_valid == e_v, e_tag, "rsp_valid", rsp_valid, e_v);
    if (e_v) begin
      check(rsp_port == e_port[1:0], e_tag, "rsp_port", rsp_port, e_port);
      check(rsp_pass == e_pass, e_tag, "rsp_pass", rsp_pass, e_pass);
      if (e_port == trk_port && !rsp_pass) trk_fail++;
    end
    req_valid = v; req_op = ops; req_addr = addrs;
    #1;
    g = -1;
    for (int i = NP - 1; i >= 0; i--) if (v[i]) g = i;
    check(req_ready == ((g >= 0) ? (NP'(1) << g) : '0), "R2", "req_ready",
          req_ready, (g >= 0) ? (1 << g) : 0);
    e_v = 0;
    e_tag = tag;
    if (g >= 0) begin
      logic [1:0]  o;
      logic [31:0] a;
      o = ops[2*g +: 2];
      a = addrs[AW*g +: AW];
      case (o)
        OP_DROP: m_mem[g] = 0;
        OP_LDEX: begin m_excl[g] = 1; m_tag[g] = a; m_mem[g] = 1; end
        OP_ST: for (int q = 0; q < NP; q++)
                 if (m_mem[q] && m_excl[q]) begin m_excl[q] = 0; m_tag[q] = 0; end
        default: begin
          bit p;
          p = 0;
          if (m_excl[g] && m_tag[g] == a) begin
            if (m_cnt[g] >= FM) begin m_cnt[g] = 0; p = 0; end
            else begin m_cnt[g]++; p = 1; end
            m_excl[g] = 0; m_tag[g] = 0;
          end
          if (p) for (int q = 0; q < NP; q++)
            if (q != g && m_mem[q] && m_excl[q] && (m_tag[q] / 8) == (a / 8)) begin
              m_excl[q] = 0; m_tag[q] = 0;
            end
          e_v = 1; e_port = g; e_pass = p;
        end
      endcase
    end
  endtask

  task automatic op1(input int p, input logic [1:0] o, input logic [31:0] a,
                     input string tag);
    logic [2*NP-1:0]  ob;
    logic [AW*NP-1:0] ab;
    ob = (2*NP)'(o) << (2 * p);
    ab = (AW*NP)'(a) << (AW * p);
    drive(NP'(1) << p, ob, ab, tag);
  endtask

  task automatic idle(input string tag);
    drive('0, '0, '0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) begin m_excl[i] = 0; m_mem[i] = 0; m_tag[i] = 0; m_cnt[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    check(rsp_valid == 0, "R1", "rsp_valid after reset", rsp_valid, 0);
    check(req_ready == 0, "R1", "req_ready after reset", req_ready, 0);
    for (int p = 0; p < NP; p++) op1(p, OP_STEX, 32'h0, "R1");
    idle("R1");

    // R3 / R5: reservation then exact store-exclusive, then second one fails
    op1(0, OP_LDEX, 32'h100, "R3");
    op1(0, OP_STEX, 32'h100, "R5");
    op1(0, OP_STEX, 32'h100, "R5");

    // R6 / R5: mismatch in the same granule keeps the reservation
    op1(1, OP_LDEX, 32'h204, "R3");
    op1(1, OP_STEX, 32'h200, "R6");
    op1(1, OP_STEX, 32'h204, "R6");

    // R4: plain store at an unrelated address clears everyone, requester too
    op1(0, OP_LDEX, 32'h300, "R4");
    op1(2, OP_LDEX, 32'h500, "R4");
    op1(3, OP_ST,   32'h900, "R4");
    op1(0, OP_STEX, 32'h300, "R4");
    op1(2, OP_STEX, 32'h500, "R4");
    op1(1, OP_LDEX, 32'h40, "R4");
    op1(1, OP_ST,   32'h40, "R4");
    op1(1, OP_STEX, 32'h40, "R4");

    // R7: pass clears same-granule peers only
    op1(0, OP_LDEX, 32'h1000, "R7");
    op1(1, OP_LDEX, 32'h1004, "R7");
    op1(2, OP_LDEX, 32'h1010, "R7");
    op1(0, OP_STEX, 32'h1000, "R7");
    op1(1, OP_STEX, 32'h1004, "R7");
    op1(2, OP_STEX, 32'h1010, "R7");

    // R6: a failing store-exclusive leaves peers alone
    op1(0, OP_LDEX, 32'h2000, "R6");
    op1(1, OP_LDEX, 32'h2000, "R6");
    op1(0, OP_STEX, 32'h2008, "R6");
    op1(1, OP_STEX, 32'h2000, "R6");

    // R9: dropped port is deaf to stores and peer passes until re-added
    op1(1, OP_LDEX, 32'h3000, "R9");
    op1(1, OP_DROP, 32'h0,    "R9");
    op1(0, OP_ST,   32'h3000, "R9");
    op1(1, OP_STEX, 32'h3000, "R9");
    op1(2, OP_LDEX, 32'h3100, "R9");
    op1(2, OP_DROP, 32'h0,    "R9");
    op1(0, OP_LDEX, 32'h3100, "R9");
    op1(0, OP_STEX, 32'h3100, "R9");
    op1(2, OP_STEX, 32'h3100, "R9");
    op1(2, OP_LDEX, 32'h3200, "R9");
    op1(0, OP_ST,   32'h0,    "R9");
    op1(2, OP_STEX, 32'h3200, "R9");

    // R2: simultaneous requests, lowest index wins, others re-present
    drive(4'b1110, {OP_LDEX, OP_LDEX, OP_LDEX, OP_DROP},
          {32'h4030, 32'h4020, 32'h4010, 32'h0}, "R2");
    drive(4'b1100, {OP_LDEX, OP_LDEX, OP_DROP, OP_DROP},
          {32'h4030, 32'h4020, 32'h0, 32'h0}, "R2");
    drive(4'b1000, {OP_LDEX, OP_DROP, OP_DROP, OP_DROP},
          {32'h4030, 32'h0, 32'h0, 32'h0}, "R2");
    drive(4'b0111, {OP_DROP, OP_STEX, OP_STEX, OP_STEX},
          {32'h0, 32'h4020, 32'h4010, 32'h4000}, "R2");

    // R10: back-to-back verdicts on two ports
    op1(1, OP_STEX, 32'h4010, "R10");
    op1(2, OP_STEX, 32'h4020, "R10");
    idle("R10");

    // R8: failure budget on port 3
    trk_port = 3; trk_fail = 0;
    for (int k = 0; k < 128; k++) begin
      op1(3, OP_LDEX, 32'h5000 + 32'(k * 4), "R8");
      op1(3, OP_STEX, 32'h5000 + 32'(k * 4), "R8");
    end
    idle("R8");
    idle("R8");
    check(trk_fail == 2, "R8", "budget failures in 128 matches", trk_fail, 2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule